// File: doc/BRIEF.md
# Test-Multiplexed Pad Wrapper

This block sits between the core logic and a row of pad cells. Each lane has an output path and an input path. The output path carries data and a driver enable. The input path returns the pad line to the core. Three shared test controls can hand each path over to boundary-scan cell values:

- one control for output data,
- one control for the driver enable,
- one control for the value seen by the core.

A shared force-disable input switches every driver off whatever the other enables say. The enable multiplexer output goes back to the enable cell. A sample copy of each pad line goes to the test logic.

A parameter picks the pad cell variant, and each variant uses the data pin differently:

- **Push-pull:** the cell drives the line whenever its enable is high.
- **Open-drain:** the cell pulls the line low only when its data pin is 0, so a released line carries data 1.
- **Open-source:** the cell pulls the line low only when its data pin is 1. This is the inverted data sense, and a released line carries data 0.

In the open variants, an external pull-up sets a released line to 1. When all test controls and force-disable are low, the wrapper passes the functional signals straight through.

Top module: `bscan_pad_wrap`

## Requirements
- R1: With the three select controls and force-disable all low, drv_en_o equals core_oe_i, en_fb_o equals core_oe_i, and core_di_o equals core_ie_i AND pad_line_i.
- R2: While force_dis_i is 1, drv_en_o is 0 on every lane, and in the open variants the pad line is released (reads 1 unless pulled low externally), whatever the functional and test enables are.
- R3: sel_jtag_en_i = 1 takes the selected enable from bs_oe_i, otherwise from core_oe_i; en_fb_o always shows this selected enable, before force-disable is applied.
- R4: sel_jtag_out_i = 1 takes the output data from bs_do_i, otherwise from core_do_i.
- R5: sel_jtag_in_i = 1 delivers bs_di_i to core_di_o, otherwise the gated pad line.
- R6: With sel_jtag_in_i = 0 and core_ie_i = 0 on a lane, core_di_o on that lane is 0 whatever the pad line is.
- R7: sample_o always equals pad_line_i, whatever the input enable and sel_jtag_in_i are.
- R8: With KIND = 1 (open-drain), drv_data_o is forced to 1 whenever the driver is off, and equals the selected data otherwise. The pad is low when the selected data is 0 and the driver is on.
- R9: With KIND = 2 (open-source, inverted data), drv_data_o is forced to 0 whenever the driver is off, and equals the selected data otherwise. The pad is low when the selected data is 1 and the driver is on.
- R10: With KIND = 0 (push-pull), drv_data_o equals the selected data and drv_en_o equals the selected enable AND NOT force_dis_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| core_do_i | input | N_PADS | Functional output data from the core |
| core_oe_i | input | N_PADS | Functional driver enable from the core, active high |
| core_ie_i | input | N_PADS | Functional input enable, active high |
| core_di_o | output | N_PADS | Input data delivered to the core |
| sel_jtag_out_i | input | 1 | Selects boundary-scan output data |
| sel_jtag_en_i | input | 1 | Selects boundary-scan driver enable |
| sel_jtag_in_i | input | 1 | Selects boundary-scan value toward the core |
| force_dis_i | input | 1 | Turns all drivers off, active high |
| bs_do_i | input | N_PADS | Output data value from the boundary-scan cells |
| bs_oe_i | input | N_PADS | Enable value from the boundary-scan enable cells |
| bs_di_i | input | N_PADS | Input value from the boundary-scan cells |
| en_fb_o | output | N_PADS | Selected enable, fed back to the enable cells |
| sample_o | output | N_PADS | Test copy of the pad line state |
| drv_data_o | output | N_PADS | Data pin of the pad cell driver |
| drv_en_o | output | N_PADS | Enable pin of the pad cell driver |
| pad_line_i | input | N_PADS | Pad line level as received by the pad cell |

## Verification
The block holds no state, so any wrong internal selection shows at the ports in the same cycle its inputs are applied. A wrong selection usually shows as a mismatch on drv_en_o or en_fb_o. In the open variants it can also appear as a pad line pulled low when it should be released. Such a mismatch is only visible with the external pull-up modelled and with a second device able to pull the line low, since a line that is released and a line actively driven to 1 otherwise look the same. A fault on the input side shows on core_di_o or sample_o only when the line level and the input enable differ. For this reason every combination of controls, data, enables and external pull-down is applied to all three variants.

// File: rtl/bpw_pkg.sv
package bpw_pkg;

    // Pad cell variant served by the wrapper
    typedef enum logic [1:0] {
        KIND_PUSH_PULL   = 2'd0,
        KIND_OPEN_DRAIN  = 2'd1,
        KIND_OPEN_SOURCE = 2'd2
    } drive_kind_e;

    // Output path after the test multiplexers
    typedef struct packed {
        logic data;
        logic en;
    } path_sel_t;

    // Data pin level that leaves an open-type cell released
    function automatic logic release_level(drive_kind_e kind);
        return (kind == KIND_OPEN_DRAIN);
    endfunction

endpackage

// File: rtl/bpw_out_lane.sv
module bpw_out_lane
    import bpw_pkg::*;
#(
    parameter drive_kind_e KIND = KIND_OPEN_DRAIN
) (
    input  logic core_do,
    input  logic core_oe,
    input  logic bs_do,
    input  logic bs_oe,
    input  logic sel_out,
    input  logic sel_en,
    input  logic force_dis,
    output logic en_fb,
    output logic drv_data,
    output logic drv_en
);

    path_sel_t sel;
    logic      live_en;

    always_comb begin
        sel.data = sel_out ? bs_do : core_do;
        sel.en   = sel_en  ? bs_oe : core_oe;
    end

    // Force-disable sits after the enable multiplexer and its feedback tap
    assign live_en = sel.en & ~force_dis;
    assign en_fb   = sel.en;
    assign drv_en  = live_en;

    generate
        if (KIND == KIND_PUSH_PULL) begin : g_push_pull
            assign drv_data = sel.data;
        end else begin : g_open
            // Parking the data pin keeps an open cell released while off
            localparam logic PARK = release_level(KIND);
            assign drv_data = live_en ? sel.data : PARK;
        end
    endgenerate

endmodule

// File: rtl/bpw_in_lane.sv
module bpw_in_lane (
    input  logic pad_line,
    input  logic core_ie,
    input  logic bs_di,
    input  logic sel_in,
    output logic core_di,
    output logic sample
);

    logic gated;

    assign gated   = pad_line & core_ie;
    assign core_di = sel_in ? bs_di : gated;
    // Test copy taken ahead of the gate so the core path is left alone
    assign sample  = pad_line;

endmodule

// File: rtl/bscan_pad_wrap.sv
module bscan_pad_wrap
    import bpw_pkg::*;
#(
    parameter int          N_PADS = 4,
    parameter drive_kind_e KIND   = KIND_OPEN_DRAIN
) (
    input  logic [N_PADS-1:0] core_do_i,
    input  logic [N_PADS-1:0] core_oe_i,
    input  logic [N_PADS-1:0] core_ie_i,
    output logic [N_PADS-1:0] core_di_o,
    input  logic              sel_jtag_out_i,
    input  logic              sel_jtag_en_i,
    input  logic              sel_jtag_in_i,
    input  logic              force_dis_i,
    input  logic [N_PADS-1:0] bs_do_i,
    input  logic [N_PADS-1:0] bs_oe_i,
    input  logic [N_PADS-1:0] bs_di_i,
    output logic [N_PADS-1:0] en_fb_o,
    output logic [N_PADS-1:0] sample_o,
    output logic [N_PADS-1:0] drv_data_o,
    output logic [N_PADS-1:0] drv_en_o,
    input  logic [N_PADS-1:0] pad_line_i
);

    for (genvar g = 0; g < N_PADS; g++) begin : g_lane
        bpw_out_lane #(.KIND(KIND)) u_out (
            .core_do  (core_do_i[g]),
            .core_oe  (core_oe_i[g]),
            .bs_do    (bs_do_i[g]),
            .bs_oe    (bs_oe_i[g]),
            .sel_out  (sel_jtag_out_i),
            .sel_en   (sel_jtag_en_i),
            .force_dis(force_dis_i),
            .en_fb    (en_fb_o[g]),
            .drv_data (drv_data_o[g]),
            .drv_en   (drv_en_o[g])
        );

        bpw_in_lane u_in (
            .pad_line(pad_line_i[g]),
            .core_ie (core_ie_i[g]),
            .bs_di   (bs_di_i[g]),
            .sel_in  (sel_jtag_in_i),
            .core_di (core_di_o[g]),
            .sample  (sample_o[g])
        );
    end

endmodule

// File: rtl/bpw_checker.sv
module bpw_checker
    import bpw_pkg::*;
#(
    parameter int          N_PADS = 4,
    parameter drive_kind_e KIND   = KIND_OPEN_DRAIN
) (
    input logic              sel_jtag_en_i,
    input logic              sel_jtag_in_i,
    input logic              force_dis_i,
    input logic [N_PADS-1:0] core_ie_i,
    input logic [N_PADS-1:0] bs_oe_i,
    input logic [N_PADS-1:0] pad_line_i,
    input logic [N_PADS-1:0] core_di_o,
    input logic [N_PADS-1:0] en_fb_o,
    input logic [N_PADS-1:0] sample_o,
    input logic [N_PADS-1:0] drv_data_o,
    input logic [N_PADS-1:0] drv_en_o
);

    always_comb begin
        a_r2_force_off: assert (!force_dis_i || drv_en_o == '0)
            else $error("force-disable left a driver on");
        a_r3_fb_from_cell: assert (!sel_jtag_en_i || en_fb_o == bs_oe_i)
            else $error("enable feedback not taken from enable cell");
        a_r7_sample_copy: assert (sample_o == pad_line_i)
            else $error("sample differs from pad line");
        a_r6_ie_gate: assert (sel_jtag_in_i || (core_di_o & ~core_ie_i) == '0)
            else $error("disabled input lane delivered a 1");
        if (KIND == KIND_OPEN_DRAIN) begin
            a_r8_od_park: assert ((drv_en_o | drv_data_o) == '1)
                else $error("open-drain lane off without data parked at 1");
        end
        if (KIND == KIND_OPEN_SOURCE) begin
            a_r9_os_park: assert ((drv_data_o & ~drv_en_o) == '0)
                else $error("open-source lane off without data parked at 0");
        end
    end

endmodule

bind bscan_pad_wrap bpw_checker #(.N_PADS(N_PADS), .KIND(KIND)) u_bpw_checker (
    .sel_jtag_en_i(sel_jtag_en_i),
    .sel_jtag_in_i(sel_jtag_in_i),
    .force_dis_i  (force_dis_i),
    .core_ie_i    (core_ie_i),
    .bs_oe_i      (bs_oe_i),
    .pad_line_i   (pad_line_i),
    .core_di_o    (core_di_o),
    .en_fb_o      (en_fb_o),
    .sample_o     (sample_o),
    .drv_data_o   (drv_data_o),
    .drv_en_o     (drv_en_o)
);

// File: tb/test_bscan_pad_wrap.sv
module test_bscan_pad_wrap;
    import bpw_pkg::*;

    localparam int N = 4;
    localparam int NK = 3;   // 0 open-drain, 1 open-source, 2 push-pull

    logic clk = 1'b0;
    always #2 clk = ~clk;    // 250 MHz

    logic [N-1:0] core_do, core_oe, core_ie, bs_do, bs_oe, bs_di, ext_low;
    logic sjo, sje, sji, fd;

    logic [N-1:0] di [NK];
    logic [N-1:0] fb [NK];
    logic [N-1:0] smp [NK];
    logic [N-1:0] dd [NK];
    logic [N-1:0] de [NK];
    logic [N-1:0] line [NK];

    int checks = 0;
    int errors = 0;

    // External world: pull-up, a second device that may pull low, pad cell
    function automatic logic [N-1:0] pad_model(int k, logic [N-1:0] en,
                                               logic [N-1:0] d, logic [N-1:0] ext);
        logic [N-1:0] v;
        for (int b = 0; b < N; b++) begin
            if (k == 2) v[b] = en[b] ? d[b] : ~ext[b];
            else if (k == 0) v[b] = ~((d[b] == 1'b0) | ext[b]);
            else v[b] = ~((d[b] == 1'b1) | ext[b]);
        end
        return v;
    endfunction

    always_comb begin
        for (int k = 0; k < NK; k++) line[k] = pad_model(k, de[k], dd[k], ext_low);
    end

    bscan_pad_wrap #(.N_PADS(N), .KIND(KIND_OPEN_DRAIN)) i_bscan_pad_wrap (
        .core_do_i(core_do), .core_oe_i(core_oe), .core_ie_i(core_ie), .core_di_o(di[0]),
        .sel_jtag_out_i(sjo), .sel_jtag_en_i(sje), .sel_jtag_in_i(sji), .force_dis_i(fd),
        .bs_do_i(bs_do), .bs_oe_i(bs_oe), .bs_di_i(bs_di), .en_fb_o(fb[0]),
        .sample_o(smp[0]), .drv_data_o(dd[0]), .drv_en_o(de[0]), .pad_line_i(line[0]));

    bscan_pad_wrap #(.N_PADS(N), .KIND(KIND_OPEN_SOURCE)) i_bscan_pad_wrap_os (
        .core_do_i(core_do), .core_oe_i(core_oe), .core_ie_i(core_ie), .core_di_o(di[1]),
        .sel_jtag_out_i(sjo), .sel_jtag_en_i(sje), .sel_jtag_in_i(sji), .force_dis_i(fd),
        .bs_do_i(bs_do), .bs_oe_i(bs_oe), .bs_di_i(bs_di), .en_fb_o(fb[1]),
        .sample_o(smp[1]), .drv_data_o(dd[1]), .drv_en_o(de[1]), .pad_line_i(line[1]));

    bscan_pad_wrap #(.N_PADS(N), .KIND(KIND_PUSH_PULL)) i_bscan_pad_wrap_pp (
        .core_do_i(core_do), .core_oe_i(core_oe), .core_ie_i(core_ie), .core_di_o(di[2]),
        .sel_jtag_out_i(sjo), .sel_jtag_en_i(sje), .sel_jtag_in_i(sji), .force_dis_i(fd),
        .bs_do_i(bs_do), .bs_oe_i(bs_oe), .bs_di_i(bs_di), .en_fb_o(fb[2]),
        .sample_o(smp[2]), .drv_data_o(dd[2]), .drv_en_o(de[2]), .pad_line_i(line[2]));

    typedef struct packed {
        logic [NK-1:0][N-1:0] di, fb, smp, dd, de, line;
        logic [N-1:0] core_oe;
        logic transp, sjo, sji, fd;
    } exp_t;

    exp_t sb_q[$];

    task automatic check(input bit ok, input string tag, input string what,
                         input int k, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s kind%0d actual=%b expected=%b", tag, what, k, act, exp);
        end
    endtask

    // Driver: applies one vector and pushes what the requirements predict
    task automatic drive(input logic [3:0] ctl, input logic [N-1:0][7:0] lane);
        exp_t e;
        logic [N-1:0] en_sel, live, dsel;
        @(posedge clk);
        #1;
        {sjo, sje, sji, fd} = ctl;
        for (int b = 0; b < N; b++)
            {core_do[b], core_oe[b], core_ie[b], bs_do[b], bs_oe[b], bs_di[b], ext_low[b]} = lane[b][6:0];
        en_sel = sje ? bs_oe : core_oe;                     // R3
        live   = en_sel & ~{N{fd}};                         // R2
        dsel   = sjo ? bs_do : core_do;                     // R4
        for (int k = 0; k < NK; k++) begin
            e.fb[k] = en_sel;
            e.de[k] = live;
            if (k == 2) begin                               // R10
                e.dd[k]   = dsel;
                e.line[k] = (live & dsel) | (~live & ~ext_low);
            end else if (k == 0) begin                      // R8: low when data 0
                e.dd[k]   = (live & dsel) | ~live;
                e.line[k] = ~((live & ~dsel) | ext_low);
            end else begin                                  // R9: low when data 1
                e.dd[k]   = live & dsel;
                e.line[k] = ~((live & dsel) | ext_low);
            end
            e.smp[k] = e.line[k];                           // R7
            e.di[k]  = sji ? bs_di : (core_ie & e.line[k]); // R5, R6
        end
        e.core_oe = core_oe;
        e.transp  = (ctl == 4'b0000);
        e.sjo = sjo; e.sji = sji; e.fd = fd;
        sb_q.push_back(e);
    endtask

    // Monitor: compares away from the active edge
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            exp_t e;
            string ktag;
            e = sb_q.pop_front();
            for (int k = 0; k < NK; k++) begin
                ktag = (k == 0) ? "R8" : (k == 1) ? "R9" : "R10";
                check(de[k] == e.de[k], e.fd ? "R2" : "R3", "drv_en", k, de[k], e.de[k]);
                check(fb[k] == e.fb[k], "R3", "en_fb", k, fb[k], e.fb[k]);
                check(dd[k] == e.dd[k], e.sjo ? "R4" : ktag, "drv_data", k, dd[k], e.dd[k]);
                check(line[k] == e.line[k], e.fd ? "R2" : ktag, "pad_line", k, line[k], e.line[k]);
                check(smp[k] == e.smp[k], "R7", "sample", k, smp[k], e.smp[k]);
                check(di[k] == e.di[k], e.sji ? "R5" : "R6", "core_di", k, di[k], e.di[k]);
                if (e.transp)
                    check(de[k] == e.core_oe && fb[k] == e.core_oe, "R1", "transparent_en",
                          k, de[k], e.core_oe);
            end
        end
    end

    int cyc = 0;
    bit done = 1'b0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, 150000);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [N-1:0][7:0] lane;
        {core_do, core_oe, core_ie, bs_do, bs_oe, bs_di, ext_low} = '0;
        {sjo, sje, sji, fd} = '0;
        // Idle state first (R1), then every control and lane combination
        lane = '0;
        drive(4'b0000, lane);
        for (int c = 0; c < 16; c++) begin
            for (int v = 0; v < 128; v++) begin
                for (int b = 0; b < N; b++) lane[b] = 8'((v + b * 32) % 128);
                drive(4'(c), lane);
            end
        end
        repeat (4) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule